// File: doc/BRIEF.md
# Auto-Acknowledge Packet Transmit Controller

This block is the transmit-side protocol engine of a short-range packet radio, modelled at cycle level without any modulation or physical layer. Software loads payload words into a small queue through a valid/ready write port. Each queue entry is one packet. While the chip-enable input stays high, and once it has been high long enough to count as settled, the controller launches the packet at the head of the queue. It signals each launch with a one-cycle `pkt_sent` pulse and then, if retransmission is enabled, listens for an acknowledge for a programmable window.

A packet that is acknowledged, or any packet sent with retransmission disabled, leaves the queue and raises a sticky success flag. A packet that runs out of retries raises a sticky failure flag and stays in the queue. While that flag is set, nothing more is sent. Software clears either flag by writing one to its clear input, and discards a stuck packet with the flush input. Two standby states are visible on the state output. One is used when chip-enable is low or a launch is not yet allowed. The other is used when chip-enable is high and the queue is empty.

Write port back-pressure: a word is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls when the queue is full and during a cycle in which a flush is honoured. A word offered while `wr_ready` is low is not stored, and the source must hold it until `wr_ready` returns. `cfg_retry` and `cfg_delay` are assumed stable while a packet is in flight.

Top module: `txack_ctrl`

## Requirements
- R1: A launch happens only on a clock edge at which chip-enable has already been sampled high on CE_SETTLE consecutive earlier edges. With CE_SETTLE=3, raising chip-enable with data queued gives the first `pkt_sent` pulse in the 4th cycle after the rise. Any edge that samples chip-enable low restarts the count.
- R2: Each launch, including each retransmission, shows a single-cycle `pkt_sent` pulse in its first cycle, with the head payload on `pkt_data`. The launch phase lasts TX_CYC cycles.
- R3: With `cfg_retry` = 0 the controller does not wait for an acknowledge. At the end of the launch phase it removes the packet and sets `sent_ok_flag`, after exactly one launch.
- R4: With `cfg_retry` > 0, each launch is followed by a listen window of (`cfg_delay`+1)·DELAY_UNIT cycles. An `ack_in` sampled high in that window removes the packet and sets `sent_ok_flag`.
- R5: If a window ends with no acknowledge, the packet is launched again. Successive launches of one packet are TX_CYC+(`cfg_delay`+1)·DELAY_UNIT cycles apart. After `cfg_retry`+1 launches without an acknowledge, `retry_fail_flag` is set and the packet stays queued.
- R6: While `retry_fail_flag` is set, no launch occurs even with chip-enable high and settled. Once the flag is cleared, the same packet is launched again.
- R7: Both flags are 0 after reset and are sticky. A cycle with the matching clear input high clears the flag, but a set in the same cycle wins.
- R8: The write port follows the valid/ready rule stated above. `wr_ready` is 1 after reset and 0 when FIFO_DEPTH words are held. Packets are launched in write order.
- R9: `flush` empties the queue only when the controller is in a standby state. A flush during a launch or a listen window has no effect.
- R10: `state` encodes 0 = standby-low, 1 = standby-idle, 2 = launching, 3 = listening, and is 0 after reset. From standby, a sampled-low chip-enable gives 0 on the next cycle. Chip-enable high with an empty queue gives 1, so dropping chip-enable moves 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Chip-enable: permits launches while high |
| cfg_retry | input | 4 | Number of retransmissions; 0 disables acknowledge waiting |
| cfg_delay | input | 4 | Listen window length in DELAY_UNIT steps, minus one |
| wr_valid | input | 1 | Payload word offered |
| wr_ready | output | 1 | Queue can take the offered word |
| wr_data | input | DATA_W | Payload word |
| flush | input | 1 | Discard all queued packets (honoured in standby) |
| pkt_sent | output | 1 | One-cycle pulse at the start of each launch |
| pkt_data | output | DATA_W | Payload being launched |
| ack_in | input | 1 | Acknowledge received from the far end |
| sent_ok_flag | output | 1 | Sticky: a packet was delivered |
| retry_fail_flag | output | 1 | Sticky: retries exhausted, packet kept |
| clr_sent_ok | input | 1 | Write-one-to-clear for `sent_ok_flag` |
| clr_retry_fail | input | 1 | Write-one-to-clear for `retry_fail_flag` |
| state | output | 2 | Controller state code |

## Verification
The bench builds the controller with CE_SETTLE=3, DELAY_UNIT=2, TX_CYC=2 and FIFO_DEPTH=4. These values keep every retry sequence down to a few dozen cycles. That makes it cheap to sweep every retry count 0 to 3 against window settings 0 to 2, with the acknowledge placed on every possible launch or withheld. The expected launch count, launch spacing and resulting flag are computed arithmetically for each combination. The small depth brings the full-queue back-pressure and ordering cases within a handful of writes. The short settle count lets the exact first-launch cycle and an aborted too-short enable be checked precisely.

// File: rtl/txack_pkg.sv
package txack_pkg;
  typedef enum logic [1:0] {
    ST_SB_LOW  = 2'd0,
    ST_SB_IDLE = 2'd1,
    ST_LAUNCH  = 2'd2,
    ST_LISTEN  = 2'd3
  } txack_state_e;

  localparam int FLAG_OK   = 0;
  localparam int FLAG_FAIL = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/txack_ce_gate.sv
module txack_ce_gate #(
  parameter int CE_SETTLE = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  output logic ce_ok
);
  localparam int CW = $clog2(CE_SETTLE + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    run_q <= '0;
    else if (!ce)                  run_q <= '0;
    else if (run_q != CW'(CE_SETTLE)) run_q <= run_q + 1'b1;
  end

  assign ce_ok = (run_q == CW'(CE_SETTLE));

  // R1
  ce_drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !ce_ok);
endmodule

// File: rtl/txack_flag.sv
module txack_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/txack_fifo.sv
module txack_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DATA_W-1:0]            din,
  input  logic                         pop,
  input  logic                         flush,
  output logic [DATA_W-1:0]            dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     rd_q, wr_q;
  logic [CW-1:0]     cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem_q[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= ptr_inc(wr_q);
      if (pop)  rd_q <= ptr_inc(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem_q[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R8
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/txack_ctrl.sv
module txack_ctrl
  import txack_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CE_SETTLE  = 160,
  parameter int DELAY_UNIT = 64,
  parameter int TX_CYC     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [3:0]        cfg_retry,
  input  logic [3:0]        cfg_delay,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flush,
  output logic              pkt_sent,
  output logic [DATA_W-1:0] pkt_data,
  input  logic              ack_in,
  output logic              sent_ok_flag,
  output logic              retry_fail_flag,
  input  logic              clr_sent_ok,
  input  logic              clr_retry_fail,
  output logic [1:0]        state
);
  localparam int CW      = $clog2(FIFO_DEPTH + 1);
  localparam int WIN_MAX = 16 * DELAY_UNIT;
  localparam int TMR_MAX = (TX_CYC > WIN_MAX) ? TX_CYC : WIN_MAX;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  txack_state_e   state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d, win_len;
  logic [3:0]     rty_q, rty_d;
  logic           ce_ok, is_idle, flush_eff, push, pop;
  logic           fifo_full, fifo_empty;
  logic [CW-1:0]  fifo_count;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_val;

  txack_ce_gate #(.CE_SETTLE(CE_SETTLE)) ce_gate_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .ce_ok(ce_ok)
  );

  assign is_idle   = (state_q == ST_SB_LOW) || (state_q == ST_SB_IDLE);
  assign flush_eff = flush && is_idle;
  assign wr_ready  = !fifo_full && !flush_eff;
  assign push      = wr_valid && wr_ready;

  txack_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data), .pop(pop),
    .flush(flush_eff), .dout(pkt_data), .count(fifo_count),
    .full(fifo_full), .empty(fifo_empty)
  );

  assign flag_clr[FLAG_OK]   = clr_sent_ok;
  assign flag_clr[FLAG_FAIL] = clr_retry_fail;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    txack_flag flag_i (
      .clk(clk), .rst_n(rst_n), .set(flag_set[g]), .clr(flag_clr[g]),
      .flag(flag_val[g])
    );
  end

  assign sent_ok_flag    = flag_val[FLAG_OK];
  assign retry_fail_flag = flag_val[FLAG_FAIL];

  assign win_len = (TMR_W'(cfg_delay) + TMR_W'(1)) * TMR_W'(DELAY_UNIT);

  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_q;
    rty_d    = rty_q;
    pop      = 1'b0;
    flag_set = '0;
    unique case (state_q)
      ST_SB_LOW, ST_SB_IDLE: begin
        if (!ce)                             state_d = ST_SB_LOW;
        else if (fifo_empty || flush)        state_d = ST_SB_IDLE;
        else if (ce_ok && !retry_fail_flag) begin
          state_d = ST_LAUNCH;
          tmr_d   = '0;
          rty_d   = '0;
        end else                             state_d = ST_SB_LOW;
      end
      ST_LAUNCH: begin
        if (tmr_q == TMR_W'(TX_CYC - 1)) begin
          tmr_d = '0;
          if (cfg_retry == 4'd0) begin
            pop = 1'b1;
            flag_set[FLAG_OK] = 1'b1;
            state_d = (!ce || fifo_count > CW'(1)) ? ST_SB_LOW : ST_SB_IDLE;
          end else begin
            state_d = ST_LISTEN;
          end
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_LISTEN: begin
        if (ack_in) begin
          pop = 1'b1;
          flag_set[FLAG_OK] = 1'b1;
          tmr_d   = '0;
          state_d = (!ce || fifo_count > CW'(1)) ? ST_SB_LOW : ST_SB_IDLE;
        end else if (tmr_q == win_len - 1'b1) begin
          tmr_d = '0;
          if (rty_q == cfg_retry) begin
            flag_set[FLAG_FAIL] = 1'b1;
            state_d = ST_SB_LOW;
          end else begin
            rty_d   = rty_q + 1'b1;
            state_d = ST_LAUNCH;
          end
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: state_d = ST_SB_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SB_LOW;
      tmr_q   <= '0;
      rty_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      rty_q   <= rty_d;
    end
  end

  assign pkt_sent = (state_q == ST_LAUNCH) && (tmr_q == '0);
  assign state    = state_q;

  // R1
  settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && !ce_ok) |=> state_q != ST_LAUNCH);
  // R6
  fail_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && retry_fail_flag) |=> state_q != ST_LAUNCH);
  // R10
  low_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && !ce) |=> state_q == ST_SB_LOW);
  // R4
  ack_delivers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LISTEN && ack_in) |=> sent_ok_flag);
  // R5
  fail_keeps_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_fail_flag) |-> !fifo_empty);
  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_sent |=> !pkt_sent);
endmodule

// File: tb/txack_ctrl_tb_top.sv
module txack_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, DEPTH = 4, SETTLE = 3, UNIT = 2, TXC = 2;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0;
  logic [3:0] cfg_retry = '0, cfg_delay = '0;
  logic wr_valid = 1'b0, flush = 1'b0, ack_in = 1'b0;
  logic clr_sent_ok = 1'b0, clr_retry_fail = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, pkt_sent, sent_ok_flag, retry_fail_flag;
  logic [DW-1:0] pkt_data;
  logic [1:0] state;

  int total = 0, bad = 0, cyc = 0, n_sent = 0, case_base = 0;
  int gap_exp = 0, gap_bad = 0, last_cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] log_d [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  txack_ctrl #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .CE_SETTLE(SETTLE),
               .DELAY_UNIT(UNIT), .TX_CYC(TXC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cfg_retry(cfg_retry), .cfg_delay(cfg_delay),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .flush(flush),
    .pkt_sent(pkt_sent), .pkt_data(pkt_data), .ack_in(ack_in),
    .sent_ok_flag(sent_ok_flag), .retry_fail_flag(retry_fail_flag),
    .clr_sent_ok(clr_sent_ok), .clr_retry_fail(clr_retry_fail), .state(state)
  );

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && pkt_sent) begin
      log_d[n_sent % 1024] = pkt_data;
      if (gap_exp > 0 && n_sent > case_base && (cyc - last_cyc) != gap_exp) gap_bad++;
      last_cyc = cyc;
      n_sent++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk);
    clr_sent_ok = 1'b1; clr_retry_fail = 1'b1;
    @(negedge clk);
    clr_sent_ok = 1'b0; clr_retry_fail = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  // Sweep case: ack on launch number ack_on (0 = never)
  task automatic run_case(input int arc, input int ard, input int ack_on, input logic [DW-1:0] d);
    int exp_n, got_n, gb0;
    bit exp_ok, acked;
    cfg_retry = 4'(arc); cfg_delay = 4'(ard);
    push(d);
    case_base = n_sent; gb0 = gap_bad;
    gap_exp = TXC + (ard + 1) * UNIT;
    @(negedge clk); ce = 1'b1;
    acked = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      ack_in = 1'b0;
      if (sent_ok_flag || retry_fail_flag) break;
      if (!acked && ack_on != 0 && state == 2'd3 && (n_sent - case_base) == ack_on) begin
        ack_in = 1'b1; acked = 1'b1;
      end
    end
    ce = 1'b0; ack_in = 1'b0;
    gap_exp = 0;
    exp_ok = (arc == 0) || (ack_on >= 1 && ack_on <= arc + 1);
    exp_n  = (arc == 0) ? 1 : (exp_ok ? ack_on : arc + 1);
    got_n  = n_sent - case_base;
    chk(got_n == exp_n, "R3/R4/R5 launch count", got_n, exp_n);
    chk(sent_ok_flag == exp_ok, "R3/R4 sent_ok_flag", sent_ok_flag, exp_ok);
    chk(retry_fail_flag == !exp_ok, "R5 retry_fail_flag", retry_fail_flag, !exp_ok);
    chk(gap_bad == gb0, "R5 retry spacing", gap_bad - gb0, 0);
    for (int k = case_base; k < n_sent; k++)
      chk(log_d[k % 1024] == d, "R2 payload", log_d[k % 1024], d);
    if (!exp_ok) begin
      got_n = n_sent;
      @(negedge clk); ce = 1'b1;
      negs(20);
      chk(n_sent == got_n, "R6 blocked while fail set", n_sent - got_n, 0);
      ce = 1'b0;
      @(negedge clk);
      do_flush();
      clr_flags();
      @(negedge clk); ce = 1'b1;
      negs(10);
      chk(state == 2'd1, "R9 flush emptied queue", state, 1);
      chk(n_sent == got_n, "R9 nothing left to send", n_sent - got_n, 0);
      ce = 1'b0;
    end else begin
      clr_flags();
      chk(!sent_ok_flag, "R7 write-one clear", sent_ok_flag, 0);
    end
    negs(2);
  endtask

  initial begin
    int base, t, cnt;
    negs(3);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(state == 2'd0, "R10 reset state", state, 0);
    chk(!sent_ok_flag && !retry_fail_flag, "R7 reset flags", {sent_ok_flag, retry_fail_flag}, 0);
    chk(wr_ready == 1'b1, "R8 reset ready", wr_ready, 1);
    chk(pkt_sent == 1'b0, "R2 reset pulse", pkt_sent, 0);

    // R10 standby transitions
    ce = 1'b1; @(negedge clk);
    chk(state == 2'd1, "R10 ce high empty", state, 1);
    negs(5);
    chk(state == 2'd1, "R10 stays idle", state, 1);
    ce = 1'b0; @(negedge clk);
    chk(state == 2'd0, "R10 ce drop", state, 0);

    // R1 too-short enable then exact first-launch cycle
    cfg_retry = 4'd0; cfg_delay = 4'd0;
    push(8'hA5);
    base = n_sent;
    ce = 1'b1; negs(SETTLE); ce = 1'b0;
    negs(10);
    chk(n_sent == base, "R1 short enable", n_sent - base, 0);
    ce = 1'b1; t = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (pkt_sent && t == 0) t = i;
    end
    chk(t == SETTLE + 1, "R1 first launch cycle", t, SETTLE + 1);
    chk(sent_ok_flag == 1'b1, "R3 no-wait success", sent_ok_flag, 1);
    chk(state == 2'd1, "R10 idle after last packet", state, 1);
    ce = 1'b0;
    clr_flags();

    // Sweep
    for (int arc = 0; arc <= 3; arc++)
      for (int ard = 0; ard <= 2; ard++)
        for (int ak = 0; ak <= arc + 2; ak++)
          run_case(arc, ard, ak, 8'(16 * arc + 4 * ard + ak));

    // R6 resume after clearing failure
    cfg_retry = 4'd1; cfg_delay = 4'd0;
    push(8'h3C);
    @(negedge clk); ce = 1'b1;
    for (int i = 0; i < 200 && !retry_fail_flag; i++) @(negedge clk);
    base = n_sent;
    negs(20);
    chk(n_sent == base, "R6 hold while flag set", n_sent - base, 0);
    @(negedge clk); clr_retry_fail = 1'b1;
    @(negedge clk); clr_retry_fail = 1'b0;
    for (int i = 0; i < 20 && n_sent == base; i++) @(negedge clk);
    chk(n_sent == base + 1, "R6 relaunch after clear", n_sent - base, 1);
    chk(log_d[base % 1024] == 8'h3C, "R6 same packet", log_d[base % 1024], 8'h3C);
    for (int i = 0; i < 20 && state != 2'd3; i++) @(negedge clk);
    ack_in = 1'b1; @(negedge clk); ack_in = 1'b0;
    chk(sent_ok_flag == 1'b1, "R4 ack after resume", sent_ok_flag, 1);
    ce = 1'b0; clr_flags();

    // R8 full queue and order
    for (int i = 0; i < DEPTH; i++) push(8'(8'hC0 + i));
    @(negedge clk);
    chk(wr_ready == 1'b0, "R8 full ready low", wr_ready, 0);
    wr_valid = 1'b1; wr_data = 8'hEE; @(negedge clk); wr_valid = 1'b0;
    cfg_retry = 4'd0; base = n_sent;
    ce = 1'b1; negs(60);
    chk(n_sent - base == DEPTH, "R8 extra word dropped", n_sent - base, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      chk(log_d[(base + i) % 1024] == 8'(8'hC0 + i), "R8 order", log_d[(base + i) % 1024], 8'hC0 + i);
    ce = 1'b0; clr_flags();

    // R7 set wins over held clear
    push(8'h77);
    clr_sent_ok = 1'b1; cnt = 0;
    @(negedge clk); ce = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sent_ok_flag) cnt++;
    end
    chk(cnt == 1, "R7 set beats clear", cnt, 1);
    clr_sent_ok = 1'b0; ce = 1'b0; negs(2);

    // R9 flush ignored while listening
    cfg_retry = 4'd2; cfg_delay = 4'd1;
    push(8'h11); push(8'h22);
    base = n_sent;
    @(negedge clk); ce = 1'b1;
    for (int i = 0; i < 40 && state != 2'd3; i++) @(negedge clk);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    ack_in = 1'b1; @(negedge clk); ack_in = 1'b0;
    for (int i = 0; i < 40 && !(state == 2'd3 && n_sent - base == 2); i++) @(negedge clk);
    chk(n_sent - base == 2, "R9 flush in listen ignored", n_sent - base, 2);
    chk(log_d[(base + 1) % 1024] == 8'h22, "R9 second packet kept", log_d[(base + 1) % 1024], 8'h22);
    ack_in = 1'b1; @(negedge clk); ack_in = 1'b0;
    negs(2);
    chk(state == 2'd1, "R10 empty after both", state, 1);
    ce = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule